// File: doc/BRIEF.md
# Receive Loss-of-Signal and Reacquisition Supervisor

This block sits beside a receive clock-recovery loop and decides two things each reference clock cycle. First, which serial stream reaches the recovery logic: the line stream, or a diagnostic stream looped back from a local transmitter. Second, whether the loop should train on the reference clock or track the incoming data. When the optical front end reports loss of signal, the line stream is blanked to a constant zero and the lock indication is withheld. This stops the loop from chasing noise on a dark fibre.

Training on the reference is commanded after reset and for as long as loss of signal is present. It is also commanded once the selected stream has stayed at one level for a programmable number of reference cycles, which corresponds to about 16 ms at the line reference rate. Once none of these conditions hold, the supervisor waits until the loop's lock indication has held for a run of consecutive cycles. Only then does it release the loop to track data.

A three-state machine carries the decision. `ACQ_HOLD` means a training condition is present. `ACQ_QUALIFY` means the conditions have cleared and a run of lock cycles is being counted. `ACQ_TRACK` means the loop follows the data. The transitions are:
- HOLD→QUALIFY when no training condition is present.
- QUALIFY→HOLD on any training condition.
- QUALIFY→TRACK when the lock run completes.
- TRACK→HOLD on any training condition.
- Reset places the machine in HOLD from any state.

Top module: `rx_acq_supervisor`

## Requirements
- R1: With `loop_sel` = 1 the output `data_out` follows `pri_data` (subject to R2); with `loop_sel` = 0 it follows `lpb_data`, which loss of signal never blanks.
- R2: While `los` = 1 the line path is forced to 0, so `data_out` = 0 whenever `loop_sel` = 1.
- R3: `lock_det` = 1 exactly when the machine is in tracking (`train_ref` = 0), `pll_locked` = 1 and `los` = 0; it is combinational in `pll_locked` and `los`.
- R4: While `rst_n` = 0, and on the first cycle after its release, `train_ref` = 1 and `lock_det` = 0.
- R5: After any rising clock edge that samples `los` = 1, `train_ref` = 1 until the requalification of R7 completes.
- R6: If the selected stream (`data_out`) shows no transition across QUIET_LIMIT consecutive clock edges, then after the next edge `train_ref` = 1.
- R7: Leaving training needs one edge with no training condition present (HOLD to QUALIFY). It then needs LOCK_CYCLES consecutive edges that sample `pll_locked` = 1 with no training condition, after which `train_ref` = 0. A cycle with `pll_locked` = 0 restarts the count.
- R8: A transition on the selected stream restarts the quiet measurement, so a level held for fewer than QUIET_LIMIT edges never causes training.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| los | input | 1 | Loss of optical signal, active high |
| loop_sel | input | 1 | 1 selects the line stream, 0 selects the loopback stream |
| pri_data | input | 1 | Sampled line serial data |
| lpb_data | input | 1 | Sampled diagnostic loopback data |
| pll_locked | input | 1 | Lock indication from the loop's phase detector |
| data_out | output | 1 | Selected and blanked data toward the recovery loop |
| lock_det | output | 1 | Qualified lock-detect indication |
| train_ref | output | 1 | 1 commands the loop to train on the reference clock |

## Verification
The bench drives a quiet line held one cycle short of the limit and another held exactly to it. A timer off by one either drops tracking on a healthy but sparse stream, or never drops it on a dead line. A lock indication that falls inside the qualification run must restart the count. A design that only counts total locked cycles would release the loop too early. Loss of signal is raised while in loopback mode: the loopback stream must still pass while lock-detect stays low, and a design that blanks the mux output instead of the line path would zero it. A reset issued while tracking must return training at once, with no lingering lock-detect.

// File: rtl/rx_acq_pkg.sv
package rx_acq_pkg;

    // Acquisition supervisor states.
    typedef enum logic [1:0] {
        ACQ_HOLD    = 2'd0,   // a training condition is present
        ACQ_QUALIFY = 2'd1,   // conditions cleared, counting lock run
        ACQ_TRACK   = 2'd2    // loop follows the data
    } acq_state_t;

    // Default quiet limit: about 16 ms at a 77.76 MHz reference.
    localparam int unsigned QUIET_LIMIT_DEFAULT = 1244160;
    localparam int unsigned LOCK_CYCLES_DEFAULT = 64;

endpackage

// File: rtl/rx_data_select.sv
module rx_data_select (
    input  logic loop_sel,
    input  logic los,
    input  logic pri_data,
    input  logic lpb_data,
    output logic data_sel
);

    logic pri_blanked;

    // Loss of signal blanks only the line path.
    always_comb begin
        pri_blanked = los ? 1'b0 : pri_data;
    end

    always_comb begin
        data_sel = loop_sel ? pri_blanked : lpb_data;
    end

endmodule

// File: rtl/rx_quiet_timer.sv
module rx_quiet_timer #(
    parameter int unsigned QUIET_LIMIT = rx_acq_pkg::QUIET_LIMIT_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic quiet
);

    localparam int unsigned QCW = $clog2(QUIET_LIMIT + 1);
    localparam logic [QCW-1:0] QLIM = QCW'(QUIET_LIMIT);

    logic           data_prev;
    logic           edge_seen;
    logic [QCW-1:0] quiet_cnt;

    // Transition detector on the selected stream.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_prev <= 1'b0;
        end else begin
            data_prev <= data_in;
        end
    end

    always_comb begin
        edge_seen = (data_in != data_prev);
    end

    // Saturating count of edges without a transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (edge_seen) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != QLIM) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    always_comb begin
        quiet = (quiet_cnt == QLIM);
    end

endmodule

// File: rtl/rx_acq_fsm.sv
module rx_acq_fsm
    import rx_acq_pkg::*;
#(
    parameter int unsigned LOCK_CYCLES = LOCK_CYCLES_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic los,
    input  logic quiet,
    input  logic pll_locked,
    output logic train_ref,
    output logic lock_det
);

    localparam int unsigned LCW = $clog2(LOCK_CYCLES + 1);
    localparam logic [LCW-1:0] LAST_RUN = LCW'(LOCK_CYCLES - 1);

    acq_state_t     state, state_nxt;
    logic [LCW-1:0] run_cnt, run_cnt_nxt;
    logic           hold_req;

    always_comb begin
        hold_req = los | quiet;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ACQ_HOLD;
            run_cnt <= '0;
        end else begin
            state   <= state_nxt;
            run_cnt <= run_cnt_nxt;
        end
    end

    // Next state and lock-run count.
    always_comb begin
        state_nxt   = state;
        run_cnt_nxt = '0;
        unique case (state)
            ACQ_HOLD: begin
                if (!hold_req) begin
                    state_nxt = ACQ_QUALIFY;
                end
            end
            ACQ_QUALIFY: begin
                if (hold_req) begin
                    state_nxt = ACQ_HOLD;
                end else if (pll_locked) begin
                    if (run_cnt == LAST_RUN) begin
                        state_nxt = ACQ_TRACK;
                    end else begin
                        run_cnt_nxt = run_cnt + 1'b1;
                    end
                end
            end
            ACQ_TRACK: begin
                if (hold_req) begin
                    state_nxt = ACQ_HOLD;
                end
            end
            default: begin
                state_nxt = ACQ_HOLD;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        train_ref = (state != ACQ_TRACK);
        lock_det  = (state == ACQ_TRACK) && pll_locked && !los;
    end

endmodule

// File: rtl/rx_acq_supervisor.sv
module rx_acq_supervisor #(
    parameter int unsigned QUIET_LIMIT = rx_acq_pkg::QUIET_LIMIT_DEFAULT,
    parameter int unsigned LOCK_CYCLES = rx_acq_pkg::LOCK_CYCLES_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic los,
    input  logic loop_sel,
    input  logic pri_data,
    input  logic lpb_data,
    input  logic pll_locked,
    output logic data_out,
    output logic lock_det,
    output logic train_ref
);

    logic data_sel;
    logic quiet;

    rx_data_select u_sel (
        .loop_sel (loop_sel),
        .los      (los),
        .pri_data (pri_data),
        .lpb_data (lpb_data),
        .data_sel (data_sel)
    );

    rx_quiet_timer #(.QUIET_LIMIT(QUIET_LIMIT)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_sel),
        .quiet   (quiet)
    );

    rx_acq_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .los        (los),
        .quiet      (quiet),
        .pll_locked (pll_locked),
        .train_ref  (train_ref),
        .lock_det   (lock_det)
    );

    assign data_out = data_sel;

endmodule

// File: rtl/rx_acq_checker.sv
module rx_acq_checker (
    input logic clk,
    input logic rst_n,
    input logic los,
    input logic loop_sel,
    input logic lpb_data,
    input logic pll_locked,
    input logic data_out,
    input logic lock_det,
    input logic train_ref
);

    // R1: loopback stream reaches the output regardless of loss of signal.
    assert_loopback_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_sel |-> data_out == lpb_data);

    // R2: line path blanked during loss of signal.
    assert_los_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_sel && los) |-> !data_out);

    // R3: lock-detect only while tracking, locked and with signal present.
    assert_lock_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_det |-> (!train_ref && pll_locked && !los));

    // R4: reset holds training and withholds lock-detect.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_train_R4: assert (train_ref && !lock_det);
        end
    end

    // R5: sampled loss of signal forces training after the edge.
    assert_los_train_R5: assert property (@(posedge clk) disable iff (!rst_n)
        los |=> train_ref);

    // R7: entry to tracking follows a sampled lock indication.
    assert_track_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_ref) |-> ($past(pll_locked) && !$past(los)));

endmodule

bind rx_acq_supervisor rx_acq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .los        (los),
    .loop_sel   (loop_sel),
    .lpb_data   (lpb_data),
    .pll_locked (pll_locked),
    .data_out   (data_out),
    .lock_det   (lock_det),
    .train_ref  (train_ref)
);

// File: tb/rx_acq_supervisor_tb.sv
module rx_acq_supervisor_tb;

    localparam int QL = 40;
    localparam int LC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic los = 1'b0;
    logic loop_sel = 1'b1;
    logic pri_data = 1'b0;
    logic lpb_data = 1'b0;
    logic pll_locked = 1'b0;
    logic data_out, lock_det, train_ref;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 hold, 1 qualify, 2 track.
    int m_state = 0;
    int m_run = 0;
    int m_qcnt = 0;
    int m_prev = 0;

    always #10 clk = ~clk;

    rx_acq_supervisor #(.QUIET_LIMIT(QL), .LOCK_CYCLES(LC)) u_dut (
        .clk(clk), .rst_n(rst_n), .los(los), .loop_sel(loop_sel),
        .pri_data(pri_data), .lpb_data(lpb_data), .pll_locked(pll_locked),
        .data_out(data_out), .lock_det(lock_det), .train_ref(train_ref)
    );

    function automatic int model_sel();
        if (loop_sel) return (los ? 0 : int'(pri_data));
        return int'(lpb_data);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_run = 0; m_qcnt = 0; m_prev = 0;
        end else begin
            int s;
            bit hold;
            s = model_sel();
            hold = los || (m_qcnt == QL);
            if (m_state == 0) begin
                if (!hold) m_state = 1;
                m_run = 0;
            end else if (m_state == 1) begin
                if (hold) begin
                    m_state = 0; m_run = 0;
                end else if (pll_locked) begin
                    m_run++;
                    if (m_run == LC) begin m_state = 2; m_run = 0; end
                end else begin
                    m_run = 0;
                end
            end else begin
                if (hold) m_state = 0;
            end
            if (s != m_prev) m_qcnt = 0;
            else if (m_qcnt < QL) m_qcnt++;
            m_prev = s;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        check("R1/R2 data_out", data_out, logic'(model_sel()));
        check("R4/R5/R6/R7 train_ref", train_ref, logic'(m_state != 2));
        check("R3 lock_det", lock_det, logic'(m_state == 2 && pll_locked && !los));
    endtask

    task automatic cyc(input logic rn, input logic ls, input logic sel,
                       input logic pd, input logic ld, input logic lk);
        @(negedge clk);
        rst_n = rn; los = ls; loop_sel = sel;
        pri_data = pd; lpb_data = ld; pll_locked = lk;
        #5;
        compare();
    endtask

    // Toggling primary data with given lock and los values.
    task automatic run_toggle(input int n, input logic ls, input logic lk);
        for (int i = 0; i < n; i++) cyc(1'b1, ls, 1'b1, logic'(i % 2), 1'b0, lk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R4: reset state.
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b1, logic'(i % 2), 1'b0, 1'b1);
        check("R4 train_ref in reset", train_ref, 1'b1);
        check("R4 lock_det in reset", lock_det, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R4 train_ref after release", train_ref, 1'b1);

        // R7: qualification then tracking.
        run_toggle(LC + 3, 1'b0, 1'b1);
        check("R7 tracking reached", train_ref, 1'b0);
        check("R3 lock_det tracking", lock_det, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3 lock_det follows pll_locked", lock_det, 1'b0);

        // R5 and R2: loss of signal.
        run_toggle(6, 1'b1, 1'b1);
        check("R5 training during los", train_ref, 1'b1);
        check("R2 line blanked", data_out, 1'b0);

        // R7: lock drop inside the run restarts the count.
        run_toggle(LC - 1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_toggle(LC - 1, 1'b0, 1'b1);
        check("R7 run restarted", train_ref, 1'b1);
        run_toggle(4, 1'b0, 1'b1);
        check("R7 tracking after full run", train_ref, 1'b0);

        // R1: loopback passes while los is high.
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1, logic'(i >= 4), 1'b0, 1'b1, logic'(i % 2), 1'b1);
            check("R1 loopback not blanked", data_out, logic'(i % 2));
        end
        check("R3 lock_det low under los", lock_det, 1'b0);
        run_toggle(LC + 3, 1'b0, 1'b1);

        // R8: quiet one short of the limit keeps tracking.
        for (int i = 0; i < QL - 1; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        run_toggle(4, 1'b0, 1'b1);
        check("R8 short quiet ignored", train_ref, 1'b0);

        // R6: quiet at the limit forces training.
        for (int i = 0; i < QL + 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R6 quiet line trains", train_ref, 1'b1);
        run_toggle(LC + 4, 1'b0, 1'b1);
        check("R7 reacquired after quiet", train_ref, 1'b0);

        // R4: reset while tracking.
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R4 mid-run reset", train_ref, 1'b1);
        run_toggle(LC + 4, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule